// File: doc/BRIEF.md
# Temperature-Compensated Gate-Bias Updater

This block keeps a power transistor's gate bias tracking its temperature. A tick divider wakes it every `tick_div + 1` clock cycles. On each tick it takes the 12-bit temperature code and compares it with the code it kept from the previous tick. If the code has not changed, nothing else happens. If it has changed, the block reads a 64-word calibration table and scales the word by a per-unit slope. It then presents the corrected code as a coarse DAC word and a fine DAC word, together with a one-cycle update strobe.

The block comes out of reset in shutdown. It starts working only after the active-low standby pin goes from low to high. A separate zero-force input drives both DAC words to zero at once, without passing through any control path. Dropping the standby pin or raising zero-force also discards the stored temperature. The first tick after the block is enabled again therefore always produces a fresh update. A simple write port loads the table.

Top module: `gate_bias_updater`

## Requirements
- R1: After reset, `coarse`, `fine` and `dac_upd` are zero. No update occurs while `standby_n` stays high, until `standby_n` has been seen low and then high.
- R2: While enabled, the temperature is sampled once every `tick_div + 1` cycles. With a temperature that changes on every cycle, consecutive `dac_upd` pulses are exactly `tick_div + 1` cycles apart.
- R3: A sample equal to the previously stored code gives no `dac_upd`, and `coarse` and `fine` keep their values. Any difference in the full 12-bit code triggers an update.
- R4: The table address is `temp_code[11:6]`. Asserting `lut_we` writes `lut_wdata` to word `lut_waddr`, and later updates use the new word.
- R5: The corrected code is the table word multiplied by `slope`, an unsigned number with 14 fraction bits (0x4000 = 1.0). The product is rounded half up at bit 14 and saturated to 0xFFFF.
- R6: `coarse` = corrected[15:8] and `fine` = {corrected[7:0], 2'b00`}. The two low bits of `fine` are always zero.
- R7: `dac_upd` is high for exactly one cycle, in the same cycle in which the new `coarse` and `fine` values first appear.
- R8: While `zero_force` is high, `coarse` and `fine` are zero in the same cycle and no `dac_upd` is issued. After release, the next tick produces an update even if the temperature is unchanged.
- R9: While `standby_n` is low, `coarse` and `fine` are zero from the next cycle onward and no `dac_upd` occurs. A later rising edge re-enables the block, and its first tick produces an update even with an unchanged temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n | input | 1 | Active-low standby; a rising edge enables the block |
| zero_force | input | 1 | Forces both DAC words to zero immediately |
| tick_div | input | 16 | Sample interval minus one, in cycles |
| slope | input | 16 | Calibration multiplier, unsigned, 14 fraction bits |
| temp_code | input | 12 | Current temperature reading |
| lut_we | input | 1 | Table write enable |
| lut_waddr | input | 6 | Table write address |
| lut_wdata | input | 16 | Table write data |
| coarse | output | 8 | Coarse DAC word |
| fine | output | 10 | Fine DAC word |
| dac_upd | output | 1 | One-cycle strobe on each new DAC code |

## Verification
An update that is already in flight through the read and scale stages can meet a rising `zero_force` in the same cycle in which its strobe would appear. The bench provokes this by changing the temperature and then raising `zero_force` at each offset from 0 to 11 cycles later, so that the clamp sweeps across the whole pipeline. At every offset it requires zero DAC words in the cycle the clamp rises and no strobe while the clamp is held. After release it requires a fresh update whose value is computed from the table model.

// File: rtl/gbu_pkg.sv
package gbu_pkg;
  typedef enum logic {MODE_OFF = 1'b0, MODE_RUN = 1'b1} bias_mode_t;
endpackage

// File: rtl/gbu_tick.sv
module gbu_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= '0;
    else if (cnt_q == limit) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == limit);
endmodule

// File: rtl/gbu_lut.sv
module gbu_lut #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gbu_scale.sv
module gbu_scale #(
  parameter int CODE_W  = 16,
  parameter int SLOPE_W = 16,
  parameter int FRAC_W  = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  input  logic [CODE_W-1:0]  code_in,
  input  logic [SLOPE_W-1:0] slope,
  output logic               out_valid,
  output logic [CODE_W-1:0]  code_out
);
  localparam int PROD_W = CODE_W + SLOPE_W;
  localparam int SH_W   = PROD_W - FRAC_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rnd;
  logic [SH_W-1:0]   shifted;
  logic              over;
  logic [CODE_W-1:0] sat;

  assign prod    = PROD_W'(code_in) * PROD_W'(slope);
  assign rnd     = prod + HALF;
  assign shifted = SH_W'(rnd >> FRAC_W);
  assign over    = |shifted[SH_W-1:CODE_W];
  assign sat     = over ? {CODE_W{1'b1}} : shifted[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
      code_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) code_out <= sat;
    end
  end
endmodule

// File: rtl/gate_bias_updater.sv
module gate_bias_updater #(
  parameter int TEMP_W   = 12,
  parameter int IDX_W    = 6,
  parameter int CODE_W   = 16,
  parameter int SLOPE_W  = 16,
  parameter int FRAC_W   = 14,
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 10,
  parameter int DIV_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                standby_n,
  input  logic                zero_force,
  input  logic [DIV_W-1:0]    tick_div,
  input  logic [SLOPE_W-1:0]  slope,
  input  logic [TEMP_W-1:0]   temp_code,
  input  logic                lut_we,
  input  logic [IDX_W-1:0]    lut_waddr,
  input  logic [CODE_W-1:0]   lut_wdata,
  output logic [COARSE_W-1:0] coarse,
  output logic [FINE_W-1:0]   fine,
  output logic                dac_upd
);
  import gbu_pkg::*;

  localparam int IDX_LSB = TEMP_W - IDX_W;
  localparam int LOW_W   = CODE_W - COARSE_W;

  bias_mode_t          mode_q;
  logic                standby_q;
  logic                active;
  logic                tick;
  logic                changed;
  logic [TEMP_W-1:0]   prev_temp_q;
  logic                prev_ok_q;
  logic                rd_v_q;
  logic [CODE_W-1:0]   lut_word;
  logic                sc_valid;
  logic [CODE_W-1:0]   corr;
  logic [FINE_W-1:0]   fine_next;
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic                upd_q;

  // enable sequencing: only a low-to-high edge on standby_n starts operation
  always_ff @(posedge clk) begin
    if (rst) begin
      standby_q <= 1'b1;
      mode_q    <= MODE_OFF;
    end else begin
      standby_q <= standby_n;
      if (!standby_n)              mode_q <= MODE_OFF;
      else if (!standby_q)         mode_q <= MODE_RUN;
    end
  end

  assign active = (mode_q == MODE_RUN) && standby_n && !zero_force;

  gbu_tick #(.CNT_W(DIV_W)) tick_i (
    .clk   (clk),
    .rst   (rst),
    .run   (active),
    .limit (tick_div),
    .tick  (tick)
  );

  assign changed = tick && (!prev_ok_q || (temp_code != prev_temp_q));

  // previous reading; invalidated whenever the block is not running
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      prev_ok_q   <= 1'b0;
      prev_temp_q <= '0;
    end else if (tick) begin
      prev_ok_q   <= 1'b1;
      prev_temp_q <= temp_code;
    end
  end

  gbu_lut #(.ADDR_W(IDX_W), .DATA_W(CODE_W)) lut_i (
    .clk   (clk),
    .we    (lut_we),
    .waddr (lut_waddr),
    .wdata (lut_wdata),
    .re    (changed),
    .raddr (temp_code[TEMP_W-1:IDX_LSB]),
    .rdata (lut_word)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) rd_v_q <= 1'b0;
    else                rd_v_q <= changed;
  end

  gbu_scale #(.CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W)) scale_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (!active),
    .in_valid  (rd_v_q),
    .code_in   (lut_word),
    .slope     (slope),
    .out_valid (sc_valid),
    .code_out  (corr)
  );

  // split corrected code into coarse and fine DAC words
  generate
    if (FINE_W > LOW_W) begin : g_pad
      assign fine_next = {corr[LOW_W-1:0], {(FINE_W-LOW_W){1'b0}}};
    end else if (FINE_W == LOW_W) begin : g_exact
      assign fine_next = corr[LOW_W-1:0];
    end else begin : g_trunc
      assign fine_next = corr[LOW_W-1 -: FINE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      coarse_q <= '0;
      fine_q   <= '0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= sc_valid;
      if (sc_valid) begin
        coarse_q <= corr[CODE_W-1:LOW_W];
        fine_q   <= fine_next;
      end
    end
  end

  assign coarse  = zero_force ? '0 : coarse_q;
  assign fine    = zero_force ? '0 : fine_q;
  assign dac_upd = upd_q && !zero_force;
endmodule

// File: rtl/gbu_checker.sv
module gbu_checker #(
  parameter int CODE_W   = 16,
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                standby_n,
  input logic                zero_force,
  input logic [COARSE_W-1:0] coarse,
  input logic [FINE_W-1:0]   fine,
  input logic                dac_upd
);
  localparam int PAD_W = FINE_W - (CODE_W - COARSE_W);

  // R8: words stay zero the cycle after the clamp was seen
  p_clamp_zero_r8: assert property (@(posedge clk) disable iff (rst)
    zero_force |=> (coarse == '0 && fine == '0));

  // R9: shutdown zeroes the words and blocks the strobe
  p_standby_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !standby_n |=> (coarse == '0 && fine == '0 && !dac_upd));

  // R9: a strobe needs the standby pin high at the preceding edge
  p_upd_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    dac_upd |-> $past(standby_n));

  // R3: outputs move only with a strobe or towards zero
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (coarse != $past(coarse) || fine != $past(fine)) |->
      (dac_upd || (coarse == '0 && fine == '0)));

  generate
    if (PAD_W > 0) begin : g_pad_chk
      // R6: padding bits of the fine word are zero
      p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
        fine[PAD_W-1:0] == '0);
    end
  endgenerate
endmodule

bind gate_bias_updater gbu_checker #(
  .CODE_W(CODE_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
) chk_i (
  .clk(clk), .rst(rst), .standby_n(standby_n), .zero_force(zero_force),
  .coarse(coarse), .fine(fine), .dac_upd(dac_upd)
);

// File: tb/gate_bias_updater_tb_top.sv
module gate_bias_updater_tb_top;
  localparam int DIV = 9;

  logic        clk = 1'b0;
  logic        rst;
  logic        standby_n;
  logic        zero_force;
  logic [15:0] tick_div;
  logic [15:0] slope;
  logic [11:0] temp_code;
  logic        lut_we;
  logic [5:0]  lut_waddr;
  logic [15:0] lut_wdata;
  logic [7:0]  coarse;
  logic [9:0]  fine;
  logic        dac_upd;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  logic [15:0] lut_m [64];

  typedef struct packed {
    logic [11:0] t;
    logic [15:0] s;
    logic        up;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{12'h000, 16'h4000, 1'b1},
    '{12'h000, 16'h4000, 1'b0},
    '{12'h03F, 16'h4000, 1'b1},
    '{12'h040, 16'h4000, 1'b1},
    '{12'h7C5, 16'h6000, 1'b1},
    '{12'hFFF, 16'h4000, 1'b1},
    '{12'hFC0, 16'h8000, 1'b1},
    '{12'h155, 16'h2000, 1'b1},
    '{12'h155, 16'h2000, 1'b0},
    '{12'hAAA, 16'h0001, 1'b1},
    '{12'h800, 16'hFFFF, 1'b1}
  };

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gate_bias_updater dut_i (
    .clk(clk), .rst(rst), .standby_n(standby_n), .zero_force(zero_force),
    .tick_div(tick_div), .slope(slope), .temp_code(temp_code),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .coarse(coarse), .fine(fine), .dac_upd(dac_upd)
  );

  function automatic logic [15:0] exp_code(input logic [11:0] t, input logic [15:0] s);
    longint p;
    p = (longint'(lut_m[t[11:6]]) * longint'(s) + 64'd8192) >> 14;
    if (p > 65535) p = 65535;
    return p[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_words(input string req, input logic [15:0] code);
    chk(req, {24'd0, coarse}, {24'd0, code[15:8]});
    chk(req, {22'd0, fine}, {22'd0, code[7:0], 2'b00});
  endtask

  task automatic wait_upd(input int maxc, output bit got);
    got = 1'b0;
    for (int i = 0; i < maxc && !got; i++) begin
      @(negedge clk);
      if (dac_upd) got = 1'b1;
    end
  endtask

  task automatic count_upd(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dac_upd) cnt++;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    bit got;
    int cnt;
    int c1;
    logic [15:0] held;
    rst = 1'b1; standby_n = 1'b1; zero_force = 1'b0; tick_div = 16'(DIV);
    slope = 16'h4000; temp_code = '0; lut_we = 1'b0; lut_waddr = '0; lut_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 coarse after reset", {24'd0, coarse}, 32'd0);
    chk("R1 fine after reset", {22'd0, fine}, 32'd0);
    chk("R1 strobe after reset", {31'd0, dac_upd}, 32'd0);

    // R4: load the table through the write port
    for (int i = 0; i < 64; i++) begin
      lut_m[i] = (i == 63) ? 16'hFFFF : 16'(i * 1031 + 76);
      lut_we = 1'b1; lut_waddr = 6'(i); lut_wdata = lut_m[i];
      @(negedge clk);
    end
    lut_we = 1'b0;

    // R1: standby held high since reset must not enable
    count_upd(40, cnt);
    chk("R1 no update without rising edge", cnt, 0);

    standby_n = 1'b0;
    repeat (2) @(negedge clk);
    standby_n = 1'b1;

    // vector table walk: R3 R4 R5 R6 R7
    held = '0;
    for (int v = 0; v < 11; v++) begin
      temp_code = VECS[v].t; slope = VECS[v].s;
      wait_upd(25, got);
      chk("R3 update taken", {31'd0, got}, {31'd0, VECS[v].up});
      if (VECS[v].up) begin
        held = exp_code(VECS[v].t, VECS[v].s);
        chk_words("R5/R6 corrected code", held);
        @(negedge clk);
        chk("R7 strobe single cycle", {31'd0, dac_upd}, 32'd0);
      end else begin
        chk_words("R3 words held", held);
      end
    end

    // R4: rewrite one word, then hit it with a fresh code in that index
    temp_code = 12'h241;
    wait_upd(25, got);
    lut_m[9] = 16'h1234;
    lut_we = 1'b1; lut_waddr = 6'd9; lut_wdata = 16'h1234; slope = 16'h4000;
    @(negedge clk);
    lut_we = 1'b0;
    temp_code = 12'h242;
    wait_upd(25, got);
    chk("R4 rewritten word used", {31'd0, got}, 32'd1);
    chk_words("R4 rewritten word value", 16'h1234);

    // R2: temperature moves every cycle, strobes spaced by the interval
    c1 = -1;
    cnt = 0;
    for (int i = 0; i < 60 && cnt < 2; i++) begin
      @(negedge clk);
      if (dac_upd) begin
        if (cnt == 1) chk("R2 tick spacing", cyc - c1, DIV + 1);
        c1 = cyc;
        cnt++;
      end
      temp_code = temp_code + 12'd1;
    end
    chk("R2 two strobes seen", cnt, 2);

    // R8: clamp swept across the update pipeline
    for (int k = 0; k < 12; k++) begin
      temp_code = (k % 2 == 1) ? 12'h100 : 12'h240;
      repeat (k) @(negedge clk);
      zero_force = 1'b1;
      #1;
      chk("R8 immediate zero coarse", {24'd0, coarse}, 32'd0);
      chk("R8 immediate zero fine", {22'd0, fine}, 32'd0);
      chk("R8 no strobe at clamp", {31'd0, dac_upd}, 32'd0);
      count_upd(6, cnt);
      chk("R8 no strobe while clamped", cnt, 0);
      zero_force = 1'b0;
      wait_upd(25, got);
      chk("R8 fresh update after release", {31'd0, got}, 32'd1);
      chk_words("R8 value after release", exp_code(temp_code, slope));
    end

    // R9: shutdown and re-enable with unchanged temperature
    standby_n = 1'b0;
    @(negedge clk);
    chk("R9 coarse zero in standby", {24'd0, coarse}, 32'd0);
    chk("R9 fine zero in standby", {22'd0, fine}, 32'd0);
    count_upd(20, cnt);
    chk("R9 no strobe in standby", cnt, 0);
    standby_n = 1'b1;
    wait_upd(25, got);
    chk("R9 fresh update after enable", {31'd0, got}, 32'd1);
    chk_words("R9 value after enable", exp_code(temp_code, slope));

    summary();
    $finish;
  end
endmodule